// File: doc/BRIEF.md
# Prioritized Exception Pend and Activation Controller

This block holds the pending and active state of a small set of prioritized exceptions. It decides which exception the processor core should enter next. Exception 0 is a deferred software exception, fixed at the lowest priority value (all ones). A scheduler uses it: interrupt handlers pend it, and it runs only once every higher-priority handler has finished. Exceptions 1 to NUM_IRQ are hardware interrupts, each with a priority supplied on `irq_prio_i`.

The core reports three things. It signals when it is stacking registers (`stk_i`), when the first handler instruction is about to issue (`first_issue_i`), and when a handler returns (`exc_ret_i`). The controller answers with the exception it has chosen, a level that marks an entry in progress, and one-cycle pulses that say whether the entry preempts the running context or chains directly from a return. Software pends or un-pends the deferred exception through a write-1 control word.

The design rests on one rule: a pending bit is removed only at activation. A request that arrives late and takes over stacking therefore leaves the original exception pending. A handler that is pended again while it is active runs again only after it returns. Returning into an already active handler is a resume, which leaves that handler's pending bit untouched. There is no data stream, so every pin is plain control or status.

Top module: `ecp_top`

## Requirements
- R1: A control write with bit 28 set makes exception 0 pending. A write with bit 27 set and bit 28 clear removes that pending state. A write whose bits 28 and 27 are both 0 changes nothing.
- R2: A control write with bits 28 and 27 both set leaves exception 0 pending.
- R3: A hardware request sets that exception's pending bit. The bit stays set while the core stacks. The cycle after `first_issue_i` during an entry, the bit is clear and the active bit is set.
- R4: Outside an entry, the best pending exception preempts if its priority value is strictly below `exec_prio_o`. The best is the lowest value, and on equal values the lowest exception number. A preempting entry raises `entry_o`, pulses `preempt_o` and shows the exception on `sel_exc_o`.
- R5: While `stk_i` is high during an entry, a pending exception with a strictly lower priority value than the current target replaces it on `sel_exc_o`. The replaced exception stays pending.
- R6: On `exc_ret_i`, the returning handler's active bit clears. The best pending exception is entered with a `tail_o` pulse if it outranks the context left behind. Otherwise the controller resumes without any entry.
- R7: An exception is never entered while it is active. When it is pended during its own activation, it is entered by tail-chaining after that activation returns.
- R8: A resume into an active handler does not clear that handler's pending bit.
- R9: `exec_prio_o` is the lowest priority value among active exceptions, zero-extended to PRIO_W+1 bits. When nothing is active it is 2^PRIO_W (thread level).
- R10: Exception 0, at priority value all-ones, is entered only when no other exception is active or outranks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_req_i | input | NUM_IRQ | Request pulse per hardware interrupt; bit k pends exception k+1 |
| irq_prio_i | input | NUM_IRQ*PRIO_W | Priority value per hardware interrupt; field k belongs to exception k+1 |
| csr_wr_i | input | 1 | Control word write strobe |
| csr_wdata_i | input | 32 | Control word; bit 28 pends exception 0, bit 27 un-pends it |
| stk_i | input | 1 | Core is stacking registers for the entry in progress |
| first_issue_i | input | 1 | First instruction of the selected handler is about to issue |
| exc_ret_i | input | 1 | Current handler executes its exception return |
| sel_exc_o | output | $clog2(NUM_IRQ+1) | Exception being entered |
| entry_o | output | 1 | Entry in progress, from the decision until activation |
| preempt_o | output | 1 | One-cycle pulse: entry with full stacking |
| tail_o | output | 1 | One-cycle pulse: entry chained from a return |
| pend_o | output | NUM_IRQ+1 | Pending bit per exception |
| act_o | output | NUM_IRQ+1 | Active bit per exception |
| exec_prio_o | output | PRIO_W+1 | Current execution priority |

## Verification
The bench builds the block with NUM_IRQ=4 and PRIO_W=8. Exceptions 1 and 3 share priority 0x40, exception 2 has 0x20 and exception 4 has 0x10. The shared value reaches the tie-break and the strict-compare refusal of an equal-priority request. The three distinct levels allow a late arrival over a pending entry, a tail-chain into a mid-level handler and a resume into a lower one. With the deferred exception left pending throughout, it also shows that exception 0 waits until the very last return.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  // control word bit positions for the deferred exception
  localparam int unsigned CSR_SET_BIT = 28;
  localparam int unsigned CSR_CLR_BIT = 27;

  typedef enum logic {
    SEQ_RUN   = 1'b0,
    SEQ_ENTER = 1'b1
  } seq_st_e;
endpackage

// File: rtl/ecp_argmin.sv
// Picks the lowest priority value among flagged entries; ties go to the lower index.
module ecp_argmin #(
  parameter int unsigned N  = 4,
  parameter int unsigned PW = 8,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]    valid_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            found_o,
  output logic [IW-1:0]   idx_o,
  output logic [PW-1:0]   prio_o
);
  logic [N:0]    f_q;
  logic [PW-1:0] p_q [N+1];
  logic [IW-1:0] x_q [N+1];

  assign f_q[0] = 1'b0;
  assign p_q[0] = '1;
  assign x_q[0] = '0;

  for (genvar g = 0; g < N; g++) begin : g_stage
    logic take;
    assign take       = valid_i[g] && (!f_q[g] || (prio_i[g*PW +: PW] < p_q[g]));
    assign f_q[g+1]   = f_q[g] | valid_i[g];
    assign p_q[g+1]   = take ? prio_i[g*PW +: PW] : p_q[g];
    assign x_q[g+1]   = take ? IW'(g) : x_q[g];
  end

  assign found_o = f_q[N];
  assign idx_o   = x_q[N];
  assign prio_o  = p_q[N];
endmodule

// File: rtl/ecp_state_bank.sv
// Pending and active bits of every exception.
module ecp_state_bank #(
  parameter int unsigned NEXC = 5,
  parameter int unsigned IW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEXC-2:0] irq_req_i,
  input  logic            swx_set_i,
  input  logic            swx_clr_i,
  input  logic            act_fire_i,
  input  logic [IW-1:0]   act_idx_i,
  input  logic            ret_fire_i,
  input  logic [IW-1:0]   ret_idx_i,
  output logic [NEXC-1:0] pend_o,
  output logic [NEXC-1:0] act_o
);
  for (genvar k = 0; k < NEXC; k++) begin : g_exc
    logic set_req, clr_req, activ, retire;
    if (k == 0) begin : g_swx
      assign set_req = swx_set_i;
      assign clr_req = swx_clr_i;
    end else begin : g_hw
      assign set_req = irq_req_i[k-1];
      assign clr_req = 1'b0;
    end
    assign activ  = act_fire_i && (act_idx_i == IW'(k));
    assign retire = ret_fire_i && (ret_idx_i == IW'(k));

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        pend_o[k] <= 1'b0;
        act_o[k]  <= 1'b0;
      end else begin
        if (set_req)                pend_o[k] <= 1'b1;
        else if (clr_req || activ)  pend_o[k] <= 1'b0;
        if (activ)                  act_o[k]  <= 1'b1;
        else if (retire)            act_o[k]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ecp_seq.sv
// Entry sequencer: preemption, late arrival, tail-chain and resume decisions.
module ecp_seq #(
  parameter int unsigned PW = 8,
  parameter int unsigned IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stk_i,
  input  logic          issue_i,
  input  logic          ret_i,
  input  logic          cur_found_i,
  input  logic          pend_found_i,
  input  logic [IW-1:0] pend_idx_i,
  input  logic [PW-1:0] pend_prio_i,
  input  logic [PW:0]   exec_prio_i,
  input  logic [PW:0]   post_prio_i,
  output logic          entering_o,
  output logic [IW-1:0] tgt_o,
  output logic          pre_pulse_o,
  output logic          tail_pulse_o,
  output logic          act_fire_o,
  output logic          ret_fire_o
);
  import ecp_pkg::*;

  seq_st_e       st_q;
  logic [PW-1:0] tgt_prio_q;
  logic          take_run, take_ret, late;

  assign take_run   = pend_found_i && ({1'b0, pend_prio_i} < exec_prio_i);
  assign take_ret   = pend_found_i && ({1'b0, pend_prio_i} < post_prio_i);
  assign late       = stk_i && pend_found_i && (pend_prio_i < tgt_prio_q);
  assign entering_o = (st_q == SEQ_ENTER);
  assign act_fire_o = (st_q == SEQ_ENTER) && issue_i;
  assign ret_fire_o = (st_q == SEQ_RUN) && ret_i && cur_found_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q         <= SEQ_RUN;
      tgt_o        <= '0;
      tgt_prio_q   <= '1;
      pre_pulse_o  <= 1'b0;
      tail_pulse_o <= 1'b0;
    end else begin
      pre_pulse_o  <= 1'b0;
      tail_pulse_o <= 1'b0;
      case (st_q)
        SEQ_RUN: begin
          if (ret_fire_o) begin
            if (take_ret) begin
              st_q         <= SEQ_ENTER;
              tgt_o        <= pend_idx_i;
              tgt_prio_q   <= pend_prio_i;
              tail_pulse_o <= 1'b1;
            end
          end else if (take_run) begin
            st_q        <= SEQ_ENTER;
            tgt_o       <= pend_idx_i;
            tgt_prio_q  <= pend_prio_i;
            pre_pulse_o <= 1'b1;
          end
        end
        SEQ_ENTER: begin
          if (issue_i) begin
            st_q <= SEQ_RUN;
          end else if (late) begin
            tgt_o      <= pend_idx_i;
            tgt_prio_q <= pend_prio_i;
          end
        end
        default: st_q <= SEQ_RUN;
      endcase
    end
  end
endmodule

// File: rtl/ecp_top.sv
module ecp_top #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 8,
  localparam int unsigned NEXC   = NUM_IRQ + 1,
  localparam int unsigned IW     = $clog2(NEXC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_IRQ-1:0]        irq_req_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio_i,
  input  logic                      csr_wr_i,
  input  logic [31:0]               csr_wdata_i,
  input  logic                      stk_i,
  input  logic                      first_issue_i,
  input  logic                      exc_ret_i,
  output logic [IW-1:0]             sel_exc_o,
  output logic                      entry_o,
  output logic                      preempt_o,
  output logic                      tail_o,
  output logic [NEXC-1:0]           pend_o,
  output logic [NEXC-1:0]           act_o,
  output logic [PRIO_W:0]           exec_prio_o
);
  import ecp_pkg::*;

  localparam logic [PRIO_W-1:0] DEF_PRIO = '1;
  localparam logic [PRIO_W:0]   THREAD   = {1'b1, {PRIO_W{1'b0}}};

  logic [NEXC*PRIO_W-1:0] prio_all;
  logic                   swx_set, swx_clr, unused_wdata;
  logic                   pend_found, cur_found, post_found;
  logic [IW-1:0]          pend_idx, cur_idx, unused_post_idx, act_idx;
  logic [PRIO_W-1:0]      pend_prio, cur_prio, post_prio;
  logic [PRIO_W:0]        post_exec;
  logic [NEXC-1:0]        act_rest;
  logic                   act_fire, ret_fire;

  assign prio_all     = {irq_prio_i, DEF_PRIO};
  assign swx_set      = csr_wr_i && csr_wdata_i[CSR_SET_BIT];
  assign swx_clr      = csr_wr_i && csr_wdata_i[CSR_CLR_BIT];
  assign unused_wdata = ^(csr_wdata_i & ~((32'd1 << CSR_SET_BIT) | (32'd1 << CSR_CLR_BIT)));

  ecp_argmin #(.N(NEXC), .PW(PRIO_W), .IW(IW)) u_pend_sel (
    .valid_i(pend_o), .prio_i(prio_all),
    .found_o(pend_found), .idx_o(pend_idx), .prio_o(pend_prio)
  );

  ecp_argmin #(.N(NEXC), .PW(PRIO_W), .IW(IW)) u_cur_sel (
    .valid_i(act_o), .prio_i(prio_all),
    .found_o(cur_found), .idx_o(cur_idx), .prio_o(cur_prio)
  );

  // active set without the current handler: the context a return goes back to
  for (genvar k = 0; k < NEXC; k++) begin : g_rest
    assign act_rest[k] = act_o[k] && (cur_idx != IW'(k));
  end

  ecp_argmin #(.N(NEXC), .PW(PRIO_W), .IW(IW)) u_post_sel (
    .valid_i(act_rest), .prio_i(prio_all),
    .found_o(post_found), .idx_o(unused_post_idx), .prio_o(post_prio)
  );

  assign exec_prio_o = cur_found  ? {1'b0, cur_prio}  : THREAD;
  assign post_exec   = post_found ? {1'b0, post_prio} : THREAD;

  ecp_seq #(.PW(PRIO_W), .IW(IW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .stk_i(stk_i), .issue_i(first_issue_i), .ret_i(exc_ret_i),
    .cur_found_i(cur_found),
    .pend_found_i(pend_found), .pend_idx_i(pend_idx), .pend_prio_i(pend_prio),
    .exec_prio_i(exec_prio_o), .post_prio_i(post_exec),
    .entering_o(entry_o), .tgt_o(act_idx),
    .pre_pulse_o(preempt_o), .tail_pulse_o(tail_o),
    .act_fire_o(act_fire), .ret_fire_o(ret_fire)
  );

  assign sel_exc_o = act_idx;

  ecp_state_bank #(.NEXC(NEXC), .IW(IW)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .irq_req_i(irq_req_i),
    .swx_set_i(swx_set), .swx_clr_i(swx_clr),
    .act_fire_i(act_fire), .act_idx_i(act_idx),
    .ret_fire_i(ret_fire), .ret_idx_i(cur_idx),
    .pend_o(pend_o), .act_o(act_o)
  );
endmodule

// File: rtl/ecp_top_chk.sv
module ecp_top_chk #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 8,
  localparam int unsigned NEXC   = NUM_IRQ + 1,
  localparam int unsigned IW     = $clog2(NEXC)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_IRQ-1:0]        irq_req_i,
  input logic [NUM_IRQ*PRIO_W-1:0] irq_prio_i,
  input logic                      csr_wr_i,
  input logic [31:0]               csr_wdata_i,
  input logic                      stk_i,
  input logic                      first_issue_i,
  input logic                      exc_ret_i,
  input logic [IW-1:0]             sel_exc_o,
  input logic                      entry_o,
  input logic                      preempt_o,
  input logic                      tail_o,
  input logic [NEXC-1:0]           pend_o,
  input logic [NEXC-1:0]           act_o,
  input logic [PRIO_W:0]           exec_prio_o
);
  import ecp_pkg::*;

  logic unused_chk;
  assign unused_chk = ^{irq_req_i, irq_prio_i, exc_ret_i};

  // R1
  swx_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_wr_i && csr_wdata_i[CSR_SET_BIT] |=> pend_o[0]);

  // R1
  swx_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_wr_i && csr_wdata_i[CSR_CLR_BIT] && !csr_wdata_i[CSR_SET_BIT] |=> !pend_o[0]);

  // R3
  stack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o && !first_issue_i && !(csr_wr_i && csr_wdata_i[CSR_CLR_BIT])
    |=> pend_o[$past(sel_exc_o)]);

  // R3
  activate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o && first_issue_i |=> act_o[$past(sel_exc_o)] && !entry_o);

  // R4
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({preempt_o, tail_o}));

  // R4
  pulse_in_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preempt_o || tail_o) |-> entry_o);

  // R5
  retarget_only_stack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o && $past(entry_o) && !$past(stk_i) |-> $stable(sel_exc_o));

  // R7
  no_self_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> !act_o[sel_exc_o]);

  // R9
  thread_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o == '0) == exec_prio_o[PRIO_W]);
endmodule

bind ecp_top ecp_top_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/ecp_top_bench.sv
`timescale 1ns/100ps
module ecp_top_bench;
  localparam int unsigned NUM_IRQ = 4;
  localparam int unsigned PRIO_W  = 8;
  localparam int unsigned NEXC    = NUM_IRQ + 1;
  localparam int unsigned IW      = $clog2(NEXC);
  localparam logic [31:0] W_SET   = 32'h1000_0000; // bit 28
  localparam logic [31:0] W_CLR   = 32'h0800_0000; // bit 27
  localparam int THREAD           = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_IRQ-1:0] irq_req = '0;
  // exc1 0x40, exc2 0x20, exc3 0x40, exc4 0x10
  logic [NUM_IRQ*PRIO_W-1:0] irq_prio = {8'h10, 8'h40, 8'h20, 8'h40};
  logic csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic stk = 1'b0, first_issue = 1'b0, exc_ret = 1'b0;
  logic [IW-1:0] sel_exc;
  logic entry, preempt, tail;
  logic [NEXC-1:0] pend, act;
  logic [PRIO_W:0] exec_prio;

  int checks = 0;
  int failures = 0;
  int exp_q[$]; // encoded kind*16 + exception: kind 0 preempt, 1 tail

  always #2.5 clk = ~clk;

  ecp_top #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_ecp_top (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .irq_prio_i(irq_prio),
    .csr_wr_i(csr_wr), .csr_wdata_i(csr_wdata), .stk_i(stk),
    .first_issue_i(first_issue), .exc_ret_i(exc_ret),
    .sel_exc_o(sel_exc), .entry_o(entry), .preempt_o(preempt), .tail_o(tail),
    .pend_o(pend), .act_o(act), .exec_prio_o(exec_prio)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic chkv(input string req, input string what, input int actual, input int expected);
    chk(actual == expected, req, what, actual, expected);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_irq(input int k);
    irq_req[k] = 1'b1; cyc(1); irq_req[k] = 1'b0;
  endtask

  task automatic csr_write(input logic [31:0] d);
    csr_wr = 1'b1; csr_wdata = d; cyc(1); csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic do_issue();
    first_issue = 1'b1; cyc(1); first_issue = 1'b0;
  endtask

  task automatic do_ret();
    exc_ret = 1'b1; cyc(1); exc_ret = 1'b0;
  endtask

  task automatic do_stack(input int n);
    stk = 1'b1; cyc(n); stk = 1'b0;
  endtask

  task automatic expect_ev(input int kind, input int exc);
    exp_q.push_back(kind * 16 + exc);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (preempt || tail)) begin
      int got;
      got = (tail ? 16 : 0) + int'(sel_exc);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected entry event", got, -1);
      end else begin
        int want;
        want = exp_q.pop_front();
        chkv(want >= 16 ? "R6" : "R4", "entry event kind*16+exc", got, want);
      end
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R9 reset state
    chkv("R9", "exec_prio after reset", int'(exec_prio), THREAD);
    chkv("R3", "pend after reset", int'(pend), 0);
    chkv("R3", "act after reset", int'(act), 0);
    chkv("R4", "entry after reset", int'(entry), 0);

    // R4 R3: exc2 preempts thread
    expect_ev(0, 2);
    pulse_irq(1);
    cyc(1);
    chkv("R4", "entry level", int'(entry), 1);
    chkv("R4", "sel exc2", int'(sel_exc), 2);
    stk = 1'b1; cyc(2);
    chkv("R3", "pend2 held while stacking", int'(pend[2]), 1);
    chkv("R3", "act2 before issue", int'(act[2]), 0);
    stk = 1'b0;
    do_issue();
    chkv("R3", "pend2 after issue", int'(pend[2]), 0);
    chkv("R3", "act2 after issue", int'(act[2]), 1);
    chkv("R9", "exec_prio exc2", int'(exec_prio), 'h20);

    // R1 R2 R10: control word writes
    csr_write(32'h0);
    chkv("R1", "zero write leaves pend0", int'(pend[0]), 0);
    csr_write(W_SET);
    chkv("R1", "set write pends exc0", int'(pend[0]), 1);
    cyc(2);
    chkv("R10", "exc0 waits below exc2", int'(entry), 0);
    csr_write(W_CLR);
    chkv("R1", "clear write", int'(pend[0]), 0);
    csr_write(W_SET | W_CLR);
    chkv("R2", "set and clear together", int'(pend[0]), 1);

    // R4: lower priority requests wait; tie between exc1 and exc3
    pulse_irq(0);
    pulse_irq(2);
    cyc(2);
    chkv("R4", "no entry for lower priority", int'(entry), 0);
    chkv("R4", "pend1 and pend3", int'({pend[3], pend[1]}), 3);

    // R6 tail-chain from exc2 picks exc1 (tie-break lower number)
    expect_ev(1, 1);
    do_ret();
    chkv("R6", "act2 cleared on return", int'(act[2]), 0);
    chkv("R4", "tie-break sel exc1", int'(sel_exc), 1);
    do_issue();
    chkv("R9", "exec_prio exc1", int'(exec_prio), 'h40);
    cyc(2);
    chkv("R4", "equal priority exc3 not taken", int'(entry), 0);

    expect_ev(1, 3);
    do_ret();
    chkv("R6", "tail to exc3", int'(sel_exc), 3);
    do_issue();
    chkv("R3", "act3", int'(act[3]), 1);

    // R5 late arrival: exc2 entry overtaken by exc4
    expect_ev(0, 2);
    pulse_irq(1);
    cyc(1);
    chkv("R4", "exc2 preempts exc3", int'(sel_exc), 2);
    stk = 1'b1;
    pulse_irq(3);
    cyc(1);
    chkv("R5", "late arrival sel exc4", int'(sel_exc), 4);
    chkv("R5", "exc2 still pending", int'(pend[2]), 1);
    stk = 1'b0;
    do_issue();
    chkv("R5", "exc4 active", int'(act[4]), 1);
    chkv("R9", "exec_prio exc4", int'(exec_prio), 'h10);

    expect_ev(1, 2);
    do_ret();
    chkv("R6", "tail to overtaken exc2", int'(sel_exc), 2);
    do_issue();
    do_ret();
    chkv("R6", "resume into exc3 no entry", int'(entry), 0);
    chkv("R6", "exc3 still active", int'(act[3]), 1);
    chkv("R9", "exec_prio back to exc3", int'(exec_prio), 'h40);
    chkv("R10", "exc0 still pending", int'(pend[0]), 1);

    // R7: re-pend exc3 while active
    pulse_irq(2);
    cyc(2);
    chkv("R7", "no self entry", int'(entry), 0);
    chkv("R7", "pend3 set while active", int'(pend[3]), 1);

    // R8: preempt by exc4, resume keeps pend3
    expect_ev(0, 4);
    pulse_irq(3);
    cyc(1);
    do_stack(2);
    do_issue();
    do_ret();
    chkv("R8", "resume, no entry", int'(entry), 0);
    chkv("R8", "pend3 kept on resume", int'(pend[3]), 1);

    expect_ev(1, 3);
    do_ret();
    chkv("R7", "exc3 re-entered after return", int'(sel_exc), 3);
    do_issue();
    chkv("R7", "pend3 cleared on activation", int'(pend[3]), 0);

    expect_ev(1, 0);
    do_ret();
    chkv("R10", "deferred entered last", int'(sel_exc), 0);
    do_issue();
    chkv("R9", "exec_prio deferred", int'(exec_prio), 'hFF);
    csr_write(W_SET);
    cyc(2);
    chkv("R7", "deferred not nested", int'(entry), 0);
    expect_ev(1, 0);
    do_ret();
    chkv("R7", "deferred chained again", int'(sel_exc), 0);
    do_issue();
    do_ret();
    chkv("R6", "final return no entry", int'(entry), 0);
    chkv("R9", "thread level", int'(exec_prio), THREAD);
    chkv("R6", "nothing pending", int'(pend), 0);
    cyc(2);
    chkv("R4", "expected events left", exp_q.size(), 0);
    finish_run();
  end
endmodule